// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block works out the next program counter of a small 8-bit core with a 12-bit program address. Bit 11 of that address acts as a bank bit. The core hands the block the following:

- the address of the last byte it fetched for the current instruction;
- a decoded instruction class, and a condition selector for conditional branches;
- the opcode byte and the second instruction byte;
- the accumulator and the working register;
- the status flags and the test inputs;
- the bank flag;
- the byte that program memory returns for an indirect lookup.

The block returns the address to fetch next and, when it needs a lookup, a program-memory read address. It also returns the updated loop register, the next value of the bank flag, and a strobe that clears the timer flag.

Long transfers (jump and call) take eleven address bits from the instruction and take bit 11 from the bank flag. All in-page branches keep the page of the incremented address and replace only the low byte. In-page branches cover conditional branches, loop-decrement branches and the accumulator-indexed branch. Sequential flow wraps inside the current 2 KiB bank and never changes bit 11.

The block is purely combinational. The core registers its outputs. The core also closes the loop through program memory: the block drives `pm_addr_o`, and the memory returns the byte on `pm_data_i`.

Top module: `pc_branch_unit`

## Requirements
- R1: For class 0 (sequential), class 5 (table read) and class 7, `pc_next_o` is `{pc_i[11], pc_i[10:0]+1}`. Bits 10:0 wrap from 7FFh to 000h and bit 11 is kept. Call this value the incremented PC.
- R2: For class 1 (long jump or call), `pc_next_o` is `{bank_i, op_i[7:5], imm_i}`.
- R3: For class 2 (conditional branch), a taken branch gives `{incremented PC[11:8], imm_i}`. A branch that is not taken gives the incremented PC.
- R4: These are the selector codes in `cond_i`. The branch is taken when the listed input is 1:
  - 0: carry
  - 1: not carry
  - 2: accumulator equals zero
  - 3: accumulator is nonzero
  - 4: flag 0
  - 5: flag 1
  - 6: test 0
  - 7: not test 0
  - 8: test 1
  - 9: not test 1
  - 11: timer flag

  Codes 10 and 12 to 15 are covered by R5 and R6.
- R5: Selector 10 is taken when accumulator bit `op_i[7:5]` is 1. Selectors 12 to 15 are never taken.
- R6: `tf_clr_o` is 1 exactly when the class is 2 and the selector is 11. This holds whether or not the branch is taken. In every other case `tf_clr_o` is 0.
- R7: For class 3 (loop decrement), `reg_next_o` is `reg_i-1` (mod 256). The branch goes to `{incremented PC[11:8], imm_i}` only if that result is nonzero; otherwise `pc_next_o` is the incremented PC. For every other class, `reg_next_o` equals `reg_i`.
- R8: For class 4 (indexed branch), `pm_rd_o` is 1 and `pm_addr_o` is `{incremented PC[11:8], acc_i}`. `pc_next_o` is `{incremented PC[11:8], pm_data_i}`.
- R9: For class 5 (table read), `pm_rd_o` is 1 and `pm_addr_o` is `300h + acc_i`. For classes 0 to 3, 6 and 7, `pm_rd_o` is 0.
- R10: For class 6 (bank select), `bank_next_o` is `op_i[4]` and `pc_next_o` is the incremented PC. For every other class, `bank_next_o` equals `bank_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 12 | Address of the last fetched byte of the instruction |
| kind_i | input | 3 | Decoded instruction class |
| cond_i | input | 4 | Branch condition selector |
| op_i | input | 8 | Opcode byte |
| imm_i | input | 8 | Second instruction byte |
| acc_i | input | 8 | Accumulator |
| reg_i | input | 8 | Selected working register |
| pm_data_i | input | 8 | Byte returned by program memory |
| carry_i | input | 1 | Carry flag |
| f0_i | input | 1 | User flag 0 |
| f1_i | input | 1 | User flag 1 |
| t0_i | input | 1 | Test input 0 |
| t1_i | input | 1 | Test input 1 |
| tf_i | input | 1 | Timer overflow flag |
| bank_i | input | 1 | Current bank flag |
| pc_next_o | output | 12 | Next program counter |
| pm_addr_o | output | 12 | Program-memory lookup address |
| pm_rd_o | output | 1 | Lookup request |
| tf_clr_o | output | 1 | Timer flag clear strobe |
| bank_next_o | output | 1 | Next bank flag |
| reg_next_o | output | 8 | Updated working register |

## Verification
The bench builds the block with its default widths: a 12-bit address, 8-bit data and table page 3. At these widths every program address can be swept for sequential flow, including both bank wraps. Every selector is swept against all 64 flag and test-input combinations, with each accumulator bit number. Every register and accumulator value is swept for the decrement and indexed forms. The page-crossing addresses 0FFh, 7FFh and 8FFh show the branch page coming from the incremented PC rather than from the fetched one.

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int TBL_PAGE = 3
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [2:0]        kind_i,
  input  logic [3:0]        cond_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] pm_data_i,
  input  logic              carry_i,
  input  logic              f0_i,
  input  logic              f1_i,
  input  logic              t0_i,
  input  logic              t1_i,
  input  logic              tf_i,
  input  logic              bank_i,
  output logic [ADDR_W-1:0] pc_next_o,
  output logic [ADDR_W-1:0] pm_addr_o,
  output logic              pm_rd_o,
  output logic              tf_clr_o,
  output logic              bank_next_o,
  output logic [DATA_W-1:0] reg_next_o
);

  localparam int PAGE_W = ADDR_W - DATA_W;
  localparam int BANK_W = ADDR_W - 1;
  localparam int HI_W   = BANK_W - DATA_W;
  localparam int BIT_W  = $clog2(DATA_W);

  localparam logic [2:0] K_SEQ   = 3'd0;
  localparam logic [2:0] K_LONG  = 3'd1;
  localparam logic [2:0] K_COND  = 3'd2;
  localparam logic [2:0] K_DJNZ  = 3'd3;
  localparam logic [2:0] K_IDX   = 3'd4;
  localparam logic [2:0] K_TABLE = 3'd5;
  localparam logic [2:0] K_BANK  = 3'd6;

  logic [BANK_W-1:0] ofs_inc;
  logic [ADDR_W-1:0] pc_inc;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] reg_dec;
  logic              cond_ok;

  assign ofs_inc = pc_i[BANK_W-1:0] + BANK_W'(1);
  assign pc_inc  = {pc_i[ADDR_W-1], ofs_inc};
  assign page    = pc_inc[ADDR_W-1:DATA_W];
  assign reg_dec = reg_i - DATA_W'(1);

  always_comb begin
    case (cond_i)
      4'd0:    cond_ok = carry_i;
      4'd1:    cond_ok = !carry_i;
      4'd2:    cond_ok = (acc_i == '0);
      4'd3:    cond_ok = (acc_i != '0);
      4'd4:    cond_ok = f0_i;
      4'd5:    cond_ok = f1_i;
      4'd6:    cond_ok = t0_i;
      4'd7:    cond_ok = !t0_i;
      4'd8:    cond_ok = t1_i;
      4'd9:    cond_ok = !t1_i;
      4'd10:   cond_ok = acc_i[op_i[DATA_W-1 -: BIT_W]];
      4'd11:   cond_ok = tf_i;
      default: cond_ok = 1'b0;
    endcase
  end

  always_comb begin
    pc_next_o = pc_inc;
    pm_addr_o = pc_inc;
    pm_rd_o   = 1'b0;
    case (kind_i)
      K_LONG: pc_next_o = {bank_i, op_i[DATA_W-1 -: HI_W], imm_i};
      K_COND: if (cond_ok) pc_next_o = {page, imm_i};
      K_DJNZ: if (reg_dec != '0) pc_next_o = {page, imm_i};
      K_IDX: begin
        pm_rd_o   = 1'b1;
        pm_addr_o = {page, acc_i};
        pc_next_o = {page, pm_data_i};
      end
      K_TABLE: begin
        pm_rd_o   = 1'b1;
        pm_addr_o = {PAGE_W'(TBL_PAGE), acc_i};
      end
      default: ;
    endcase
  end

  assign tf_clr_o    = (kind_i == K_COND) && (cond_i == 4'd11);
  assign bank_next_o = (kind_i == K_BANK) ? op_i[4] : bank_i;
  assign reg_next_o  = (kind_i == K_DJNZ) ? reg_dec : reg_i;

  always_comb begin
    if (kind_i == K_SEQ || kind_i == K_BANK)
      p_seq_bank_kept_r1: assert (pc_next_o[ADDR_W-1] == pc_i[ADDR_W-1])
        else $error("sequential flow changed the bank bit");
    if (kind_i == K_LONG)
      p_long_bank_r2: assert (pc_next_o[ADDR_W-1] == bank_i && pc_next_o[DATA_W-1:0] == imm_i)
        else $error("long target malformed");
    if (kind_i == K_COND)
      p_cond_in_page_r3: assert (pc_next_o == pc_inc || pc_next_o[ADDR_W-1:DATA_W] == pc_inc[ADDR_W-1:DATA_W])
        else $error("conditional branch left its page");
    if (tf_clr_o)
      p_tf_clear_only_test_r6: assert (kind_i == K_COND && !pm_rd_o)
        else $error("timer clear outside its test");
    if (kind_i == K_DJNZ && reg_i == DATA_W'(1))
      p_djnz_falls_through_r7: assert (pc_next_o == pc_inc && reg_next_o == '0)
        else $error("loop branch taken on zero");
    if (pm_rd_o)
      p_lookup_index_r8: assert (pm_addr_o[DATA_W-1:0] == acc_i && (kind_i == K_IDX || kind_i == K_TABLE))
        else $error("lookup address not indexed by accumulator");
    if (kind_i != K_BANK)
      p_bank_hold_r10: assert (bank_next_o == bank_i)
        else $error("bank flag moved without select");
  end

endmodule

// File: tb/pc_branch_unit_bench.sv
module pc_branch_unit_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [11:0] pc;
  logic [2:0]  kind;
  logic [3:0]  cond;
  logic [7:0]  op, imm, acc, rg, pmd;
  logic        cy, f0, f1, t0, t1, tf, bank;
  logic [11:0] pc_next, pm_addr;
  logic        pm_rd, tf_clr, bank_next;
  logic [7:0]  reg_next;

  int checks = 0;
  int errors = 0;

  pc_branch_unit u_pc_branch_unit (
    .pc_i(pc), .kind_i(kind), .cond_i(cond), .op_i(op), .imm_i(imm),
    .acc_i(acc), .reg_i(rg), .pm_data_i(pmd), .carry_i(cy), .f0_i(f0),
    .f1_i(f1), .t0_i(t0), .t1_i(t1), .tf_i(tf), .bank_i(bank),
    .pc_next_o(pc_next), .pm_addr_o(pm_addr), .pm_rd_o(pm_rd),
    .tf_clr_o(tf_clr), .bank_next_o(bank_next), .reg_next_o(reg_next));

  function automatic logic [11:0] inc_of(input logic [11:0] p);
    logic [10:0] low;
    low = p[10:0] + 11'd1;
    return {p[11], low};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (pc=%h kind=%0d cond=%0d op=%h acc=%h)",
               req, act, exp, pc, kind, cond, op, acc);
    end
  endtask

  task automatic idle();
    kind = 3'd0; cond = 4'd0; op = 8'h00; imm = 8'h00; acc = 8'h00; rg = 8'h00;
    pmd = 8'h00; {cy, f0, f1, t0, t1, tf, bank} = 7'b0;
  endtask

  logic [11:0] ex;
  logic        take;

  initial begin
    idle();
    pc = 12'h000;
    @(negedge clk);
    chk("R1 start", {20'b0, pc_next}, 32'h001);
    chk("R9 start", {31'b0, pm_rd}, 32'h0);
    chk("R6 start", {31'b0, tf_clr}, 32'h0);

    // R1 / R10: all addresses, sequential, bank select and spare class
    for (int k = 0; k < 3; k++) begin
      kind = (k == 0) ? 3'd0 : (k == 1) ? 3'd6 : 3'd7;
      for (int a = 0; a < 4096; a++) begin
        pc = a[11:0]; op = a[7:0]; bank = a[5]; rg = a[9:2];
        #1;
        chk("R1 seq", {20'b0, pc_next}, {20'b0, inc_of(pc)});
        chk("R9 no lookup", {31'b0, pm_rd}, 32'h0);
        chk("R7 reg hold", {24'b0, reg_next}, {24'b0, rg});
        chk("R10 bank", {31'b0, bank_next}, {31'b0, (kind == 3'd6) ? op[4] : bank});
        chk("R6 no clear", {31'b0, tf_clr}, 32'h0);
      end
    end
    chk("R1 wrap low", {20'b0, inc_of(12'h7FF)}, 32'h000);

    // R2: long transfers
    idle(); kind = 3'd1;
    for (int o = 0; o < 256; o++)
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 4; i++) begin
          op = o[7:0]; bank = b[0]; imm = 8'h3C ^ (8'h55 * i[7:0]); pc = 12'hFFF - 12'(o);
          #1;
          chk("R2 long", {20'b0, pc_next}, {20'b0, bank, op[7:5], imm});
          chk("R10 bank hold", {31'b0, bank_next}, {31'b0, bank});
        end

    // R3 R4 R5 R6: conditional branches
    idle(); kind = 3'd2; imm = 8'h5A;
    for (int c = 0; c < 16; c++)
      for (int fl = 0; fl < 64; fl++)
        for (int av = 0; av < 4; av++)
          for (int pv = 0; pv < 3; pv++)
            for (int bn = 0; bn < 8; bn++) begin
              cond = c[3:0];
              {cy, f0, f1, t0, t1, tf} = fl[5:0];
              acc = (av == 0) ? 8'h00 : (av == 1) ? 8'h01 : (av == 2) ? 8'h80 : 8'hA5;
              pc = (pv == 0) ? 12'h0FF : (pv == 1) ? 12'h8FF : 12'h123;
              op = {bn[2:0], 5'b10010};
              case (c)
                0: take = cy;        1: take = !cy;
                2: take = acc == 0;  3: take = acc != 0;
                4: take = f0;        5: take = f1;
                6: take = t0;        7: take = !t0;
                8: take = t1;        9: take = !t1;
                10: take = acc[bn];  11: take = tf;
                default: take = 1'b0;
              endcase
              ex = inc_of(pc);
              if (take) ex = {ex[11:8], imm};
              #1;
              chk((c == 10) ? "R5 acc bit" : (c > 11) ? "R5 never" : "R4 cond", {20'b0, pc_next}, {20'b0, ex});
              chk("R6 tf clear", {31'b0, tf_clr}, {31'b0, c == 11});
            end
    // R3 page from incremented PC: 0FFh taken lands in page 1
    cond = 4'd0; cy = 1'b1; pc = 12'h0FF; imm = 8'h10; #1;
    chk("R3 next page", {20'b0, pc_next}, 32'h110);
    pc = 12'h7FF; #1;
    chk("R3 bank wrap", {20'b0, pc_next}, 32'h010);

    // R7: loop decrement
    idle(); kind = 3'd3; imm = 8'hC3;
    for (int r = 0; r < 256; r++)
      for (int pv = 0; pv < 3; pv++) begin
        rg = r[7:0];
        pc = (pv == 0) ? 12'h2FF : (pv == 1) ? 12'hFFF : 12'h840;
        ex = inc_of(pc);
        if (r != 1) ex = {ex[11:8], imm};
        #1;
        chk("R7 djnz pc", {20'b0, pc_next}, {20'b0, ex});
        chk("R7 djnz reg", {24'b0, reg_next}, {24'b0, rg - 8'd1});
      end

    // R8: indexed branch
    idle(); kind = 3'd4;
    for (int a = 0; a < 256; a++)
      for (int pv = 0; pv < 3; pv++) begin
        acc = a[7:0]; pmd = ~a[7:0] ^ 8'h33;
        pc = (pv == 0) ? 12'h4FF : (pv == 1) ? 12'hFFF : 12'h9A0;
        ex = inc_of(pc);
        #1;
        chk("R8 rd", {31'b0, pm_rd}, 32'h1);
        chk("R8 addr", {20'b0, pm_addr}, {20'b0, ex[11:8], acc});
        chk("R8 pc", {20'b0, pc_next}, {20'b0, ex[11:8], pmd});
      end

    // R9: table read
    idle(); kind = 3'd5;
    for (int a = 0; a < 256; a++) begin
      acc = a[7:0]; pc = 12'hE00 + 12'(a);
      #1;
      chk("R9 rd", {31'b0, pm_rd}, 32'h1);
      chk("R9 addr", {20'b0, pm_addr}, 32'h300 + 32'(a));
      chk("R1 table pc", {20'b0, pc_next}, {20'b0, inc_of(pc)});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule